// File: doc/BRIEF.md
# USB Receive Descriptor Chainer

This block takes the byte stream of one incoming SETUP or OUT data packet on an endpoint and stores it into a small ring of receive descriptors. Each descriptor owns a fixed-size byte buffer, an empty flag, an interrupt-enable flag, a ring-end flag, a byte count and a three-bit status field. The first stored byte is the data PID. Bytes continue from one buffer into the next free descriptor when a buffer fills.

When the packet ends, the block requests either an ACK handshake or no handshake at all. The choice depends on the CRC-error and bit-stuff-error flags the serial engine reports. If the ring runs out of free descriptors during a packet, the remainder is discarded and an overrun bit is recorded. The serial engine, CRC logic and DMA sit outside the block. Descriptor preparation and buffer readout use a simple arm port and a combinational read port.

Top module: `rxbd_chain`

## Requirements
- R1: A packet announced with `pkt_setup`=1 is taken only when `ep_ctrl`=1. Otherwise it writes nothing, changes no descriptor and produces no handshake pulse. A packet with `pkt_setup`=0 is always taken.
- R2: Bytes are stored only into a descriptor whose empty flag is set. Storage starts at the ring's current descriptor, and the first byte goes to position 0.
- R3: When a buffer receives its last free byte, the following happens. Its empty flag clears and its count becomes BUF_BYTES. If that descriptor's interrupt flag is set, `irq` pulses for one cycle in the next cycle.
- R4: Later bytes continue into the next descriptor. The index returns to 0 after a descriptor armed with the ring-end flag, and also after index NUM_BD-1.
- R5: The first received byte (the PID) is stored at position 0 of the first descriptor. All packet bytes are stored in arrival order.
- R6: On an error-free end, a partly filled buffer is closed: its count becomes the number of bytes it holds, its status stays 0, and its interrupt is raised as in R3. `hs_ack` pulses one cycle after `pkt_end`.
- R7: On an end with a CRC error or a stuff error, `hs_none` pulses instead of `hs_ack`. Status bit 0 (CRC) and bit 1 (stuff) are written into the last descriptor used by the packet. This also applies when that descriptor was closed full exactly at the packet's last byte.
- R8: If a byte needs a descriptor that is not empty, that byte and all later bytes of the packet are dropped. Status bit 2 (overrun) is set in the descriptor closed last for the packet, and `hs_none` pulses after `pkt_end`. The ring index stays on the busy descriptor.
- R9: After reset every descriptor reads not empty with count 0 and status 0, the ring index is 0, and `irq`, `hs_ack` and `hs_none` are low.
- R10: Arming a descriptor sets its empty flag, clears its count and status, and loads its interrupt and ring-end flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_we | input | 1 | Arm the descriptor at `arm_idx` |
| arm_idx | input | IDX_W | Descriptor to arm |
| arm_irq | input | 1 | Interrupt-enable flag to load |
| arm_wrap | input | 1 | Ring-end flag to load |
| pkt_start | input | 1 | First cycle of a packet |
| pkt_setup | input | 1 | Packet follows a SETUP token (else OUT) |
| ep_ctrl | input | 1 | Addressed endpoint is a control endpoint |
| byte_valid | input | 1 | `byte_data` holds a packet byte |
| byte_data | input | 8 | Packet byte |
| pkt_end | input | 1 | Packet finished (cycle after its last byte) |
| crc_err | input | 1 | CRC error, valid with `pkt_end` |
| stuff_err | input | 1 | Bit-stuff error, valid with `pkt_end` |
| rd_idx | input | IDX_W | Descriptor to read |
| rd_pos | input | POS_W | Byte position to read |
| rd_empty | output | 1 | Empty flag of `rd_idx` |
| rd_len | output | LEN_W | Byte count of `rd_idx` |
| rd_stat | output | 3 | Status of `rd_idx` (bit0 CRC, bit1 stuff, bit2 overrun) |
| rd_data | output | 8 | Buffer byte at `rd_idx`/`rd_pos` |
| hs_ack | output | 1 | One-cycle ACK handshake request |
| hs_none | output | 1 | One-cycle pulse: packet ends with no handshake |
| irq | output | 1 | One-cycle descriptor-closed interrupt |

## Verification
A wrong ring index shows up as bytes stored in the wrong descriptor. The read port exposes this as soon as the packet ends, and the next armed descriptor stays empty when it should be filled. A wrong fill position or count corrupts the PID byte location or the byte count of the closed descriptor. A wrong error or overrun state shows on the very next cycle after `pkt_end`, as a swapped `hs_ack`/`hs_none` pulse, or as a status bit placed in the wrong descriptor. An interrupt-flag fault changes how many `irq` pulses a multi-buffer packet produces.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
   localparam int STAT_W   = 3;
   localparam int ST_CRC   = 0;
   localparam int ST_STUFF = 1;
   localparam int ST_BUSY  = 2;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RECV = 2'd1,
      S_DROP = 2'd2
   } rx_state_e;
endpackage

// File: rtl/rxbd_ring.sv
module rxbd_ring
   import rxbd_pkg::*;
#(
   parameter int NUM_BD    = 4,
   parameter int BUF_BYTES = 4,
   localparam int IDX_W = $clog2(NUM_BD),
   localparam int POS_W = $clog2(BUF_BYTES),
   localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   // arming
   input  logic              arm_we,
   input  logic [IDX_W-1:0]  arm_idx,
   input  logic              arm_irq,
   input  logic              arm_wrap,
   // byte write
   input  logic              wr_we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [POS_W-1:0]  wr_pos,
   input  logic [7:0]        wr_data,
   // close
   input  logic              cl_we,
   input  logic [IDX_W-1:0]  cl_idx,
   input  logic [LEN_W-1:0]  cl_len,
   input  logic [STAT_W-1:0] cl_stat,
   // late status merge
   input  logic              st_we,
   input  logic [IDX_W-1:0]  st_idx,
   input  logic [STAT_W-1:0] st_or,
   // query of current descriptor
   input  logic [IDX_W-1:0]  q_idx,
   output logic              q_empty,
   output logic              q_irq,
   output logic              q_wrap,
   // read port
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [POS_W-1:0]  rd_pos,
   output logic              rd_empty,
   output logic [LEN_W-1:0]  rd_len,
   output logic [STAT_W-1:0] rd_stat,
   output logic [7:0]        rd_data
);

   logic [NUM_BD-1:0]              empty_v;
   logic [NUM_BD-1:0]              irq_v;
   logic [NUM_BD-1:0]              wrap_v;
   logic [NUM_BD-1:0][LEN_W-1:0]   len_v;
   logic [NUM_BD-1:0][STAT_W-1:0]  stat_v;
   logic [7:0]                     mem [NUM_BD][BUF_BYTES];

   for (genvar g = 0; g < NUM_BD; g++) begin : g_bd
      logic              e_q, i_q, w_q;
      logic [LEN_W-1:0]  l_q;
      logic [STAT_W-1:0] s_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_q <= 1'b0;
            i_q <= 1'b0;
            w_q <= 1'b0;
            l_q <= '0;
            s_q <= '0;
         end else if (arm_we && arm_idx == IDX_W'(g)) begin
            e_q <= 1'b1;
            i_q <= arm_irq;
            w_q <= arm_wrap;
            l_q <= '0;
            s_q <= '0;
         end else begin
            if (cl_we && cl_idx == IDX_W'(g)) begin
               e_q <= 1'b0;
               l_q <= cl_len;
               s_q <= cl_stat;
            end
            if (st_we && st_idx == IDX_W'(g)) begin
               s_q <= s_q | st_or;
            end
         end
      end

      assign empty_v[g] = e_q;
      assign irq_v[g]   = i_q;
      assign wrap_v[g]  = w_q;
      assign len_v[g]   = l_q;
      assign stat_v[g]  = s_q;
   end

   always_ff @(posedge clk) begin
      if (wr_we) begin
         mem[wr_idx][wr_pos] <= wr_data;
      end
   end

   assign q_empty  = empty_v[q_idx];
   assign q_irq    = irq_v[q_idx];
   assign q_wrap   = wrap_v[q_idx];
   assign rd_empty = empty_v[rd_idx];
   assign rd_len   = len_v[rd_idx];
   assign rd_stat  = stat_v[rd_idx];
   assign rd_data  = mem[rd_idx][rd_pos];

   // R2
   wr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_we |-> empty_v[wr_idx]);

   // R3
   close_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_we && !arm_we) |=> !empty_v[$past(cl_idx)]);

   // R7
   merge_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> !empty_v[st_idx]);

endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
   import rxbd_pkg::*;
#(
   parameter int NUM_BD       = 4,
   parameter int BUF_BYTES    = 4,
   parameter bit WRAP_AT_FLAG = 1'b1,
   localparam int IDX_W = $clog2(NUM_BD),
   localparam int POS_W = $clog2(BUF_BYTES),
   localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_start,
   input  logic              pkt_setup,
   input  logic              ep_ctrl,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              pkt_end,
   input  logic              crc_err,
   input  logic              stuff_err,
   output logic [IDX_W-1:0]  q_idx,
   input  logic              q_empty,
   input  logic              q_irq,
   input  logic              q_wrap,
   output logic              wr_we,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [POS_W-1:0]  wr_pos,
   output logic [7:0]        wr_data,
   output logic              cl_we,
   output logic [IDX_W-1:0]  cl_idx,
   output logic [LEN_W-1:0]  cl_len,
   output logic [STAT_W-1:0] cl_stat,
   output logic              st_we,
   output logic [IDX_W-1:0]  st_idx,
   output logic [STAT_W-1:0] st_or,
   output logic              hs_ack,
   output logic              hs_none,
   output logic              irq
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BD - 1);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(BUF_BYTES - 1);

   rx_state_e         state_q;
   logic [IDX_W-1:0]  cur_q, last_q, nxt_idx;
   logic [POS_W-1:0]  fill_q;
   logic              have_last_q;
   logic              accept, err_any, full_now;
   logic [STAT_W-1:0] err_bits;

   if (WRAP_AT_FLAG) begin : g_wrap_flag
      assign nxt_idx = (q_wrap || cur_q == LAST_IDX) ? '0 : cur_q + 1'b1;
   end else begin : g_wrap_end
      logic unused_wrap;
      assign unused_wrap = q_wrap;
      assign nxt_idx = (cur_q == LAST_IDX) ? '0 : cur_q + 1'b1;
   end

   assign accept   = pkt_start && (!pkt_setup || ep_ctrl);
   assign err_any  = crc_err || stuff_err;
   assign full_now = (fill_q == LAST_POS);
   always_comb begin
      err_bits            = '0;
      err_bits[ST_CRC]    = crc_err;
      err_bits[ST_STUFF]  = stuff_err;
   end

   assign q_idx   = cur_q;
   assign wr_idx  = cur_q;
   assign wr_pos  = fill_q;
   assign wr_data = byte_data;
   assign cl_idx  = cur_q;
   assign st_idx  = last_q;

   always_comb begin
      wr_we   = 1'b0;
      cl_we   = 1'b0;
      cl_len  = '0;
      cl_stat = '0;
      st_we   = 1'b0;
      st_or   = '0;
      if (state_q == S_RECV) begin
         if (byte_valid) begin
            if (q_empty) begin
               wr_we = 1'b1;
               if (full_now) begin
                  cl_we  = 1'b1;
                  cl_len = LEN_W'(BUF_BYTES);
               end
            end else begin
               st_we          = have_last_q;
               st_or[ST_BUSY] = 1'b1;
            end
         end else if (pkt_end) begin
            if (fill_q != '0) begin
               cl_we   = 1'b1;
               cl_len  = LEN_W'(fill_q);
               cl_stat = err_bits;
            end else if (have_last_q && err_any) begin
               st_we = 1'b1;
               st_or = err_bits;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         cur_q       <= '0;
         last_q      <= '0;
         fill_q      <= '0;
         have_last_q <= 1'b0;
         hs_ack      <= 1'b0;
         hs_none     <= 1'b0;
         irq         <= 1'b0;
      end else begin
         hs_ack  <= 1'b0;
         hs_none <= 1'b0;
         irq     <= cl_we && q_irq;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  state_q     <= S_RECV;
                  fill_q      <= '0;
                  have_last_q <= 1'b0;
               end
            end
            S_RECV: begin
               if (byte_valid) begin
                  if (!q_empty) begin
                     state_q <= S_DROP;
                  end else if (full_now) begin
                     fill_q      <= '0;
                     last_q      <= cur_q;
                     have_last_q <= 1'b1;
                     cur_q       <= nxt_idx;
                  end else begin
                     fill_q <= fill_q + 1'b1;
                  end
               end else if (pkt_end) begin
                  if (fill_q != '0) begin
                     cur_q <= nxt_idx;
                  end
                  hs_ack  <= !err_any;
                  hs_none <= err_any;
                  state_q <= S_IDLE;
               end
            end
            S_DROP: begin
               if (pkt_end) begin
                  hs_none <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R6
   hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_ack && hs_none));

   // R6
   ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> $past(pkt_end));

   // R1
   setup_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && pkt_start && pkt_setup && !ep_ctrl) |=> state_q == S_IDLE);

endmodule

// File: rtl/rxbd_chain.sv
module rxbd_chain
   import rxbd_pkg::*;
#(
   parameter int NUM_BD       = 4,
   parameter int BUF_BYTES    = 4,
   parameter bit WRAP_AT_FLAG = 1'b1,
   localparam int IDX_W = $clog2(NUM_BD),
   localparam int POS_W = $clog2(BUF_BYTES),
   localparam int LEN_W = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_we,
   input  logic [IDX_W-1:0]  arm_idx,
   input  logic              arm_irq,
   input  logic              arm_wrap,
   input  logic              pkt_start,
   input  logic              pkt_setup,
   input  logic              ep_ctrl,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              pkt_end,
   input  logic              crc_err,
   input  logic              stuff_err,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [POS_W-1:0]  rd_pos,
   output logic              rd_empty,
   output logic [LEN_W-1:0]  rd_len,
   output logic [STAT_W-1:0] rd_stat,
   output logic [7:0]        rd_data,
   output logic              hs_ack,
   output logic              hs_none,
   output logic              irq
);

   if (NUM_BD < 2 || (NUM_BD & (NUM_BD - 1)) != 0) begin : g_bad_num
      $error("NUM_BD must be a power of two of at least 2");
   end
   if (BUF_BYTES < 2 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 2");
   end

   logic [IDX_W-1:0]  q_idx, wr_idx, cl_idx, st_idx;
   logic              q_empty, q_irq, q_wrap;
   logic              wr_we, cl_we, st_we;
   logic [POS_W-1:0]  wr_pos;
   logic [7:0]        wr_data;
   logic [LEN_W-1:0]  cl_len;
   logic [STAT_W-1:0] cl_stat, st_or;

   rxbd_seq #(
      .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES), .WRAP_AT_FLAG(WRAP_AT_FLAG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .pkt_start(pkt_start), .pkt_setup(pkt_setup), .ep_ctrl(ep_ctrl),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .pkt_end(pkt_end), .crc_err(crc_err), .stuff_err(stuff_err),
      .q_idx(q_idx), .q_empty(q_empty), .q_irq(q_irq), .q_wrap(q_wrap),
      .wr_we(wr_we), .wr_idx(wr_idx), .wr_pos(wr_pos), .wr_data(wr_data),
      .cl_we(cl_we), .cl_idx(cl_idx), .cl_len(cl_len), .cl_stat(cl_stat),
      .st_we(st_we), .st_idx(st_idx), .st_or(st_or),
      .hs_ack(hs_ack), .hs_none(hs_none), .irq(irq)
   );

   rxbd_ring #(
      .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES)
   ) u_ring (
      .clk(clk), .rst_n(rst_n),
      .arm_we(arm_we), .arm_idx(arm_idx), .arm_irq(arm_irq), .arm_wrap(arm_wrap),
      .wr_we(wr_we), .wr_idx(wr_idx), .wr_pos(wr_pos), .wr_data(wr_data),
      .cl_we(cl_we), .cl_idx(cl_idx), .cl_len(cl_len), .cl_stat(cl_stat),
      .st_we(st_we), .st_idx(st_idx), .st_or(st_or),
      .q_idx(q_idx), .q_empty(q_empty), .q_irq(q_irq), .q_wrap(q_wrap),
      .rd_idx(rd_idx), .rd_pos(rd_pos), .rd_empty(rd_empty), .rd_len(rd_len),
      .rd_stat(rd_stat), .rd_data(rd_data)
   );

   // R9
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!hs_ack && !hs_none && !irq));

endmodule

// File: tb/rxbd_chain_test.sv
`timescale 1ns/1ps
module rxbd_chain_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       arm_we, arm_irq, arm_wrap;
   logic [1:0] arm_idx;
   logic       pkt_start, pkt_setup, ep_ctrl, byte_valid, pkt_end, crc_err, stuff_err;
   logic [7:0] byte_data;
   logic [1:0] rd_idx, rd_pos;
   logic       rd_empty;
   logic [2:0] rd_len, rd_stat;
   logic [7:0] rd_data;
   logic       hs_ack, hs_none, irq;

   int checks = 0;
   int fails  = 0;
   int n_irq, n_ack, n_none;

   always #2.5 clk = ~clk;

   rxbd_chain uut (
      .clk(clk), .rst_n(rst_n),
      .arm_we(arm_we), .arm_idx(arm_idx), .arm_irq(arm_irq), .arm_wrap(arm_wrap),
      .pkt_start(pkt_start), .pkt_setup(pkt_setup), .ep_ctrl(ep_ctrl),
      .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end),
      .crc_err(crc_err), .stuff_err(stuff_err),
      .rd_idx(rd_idx), .rd_pos(rd_pos), .rd_empty(rd_empty), .rd_len(rd_len),
      .rd_stat(rd_stat), .rd_data(rd_data),
      .hs_ack(hs_ack), .hs_none(hs_none), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq)     n_irq++;
      if (hs_ack)  n_ack++;
      if (hs_none) n_none++;
   end

   // vector: {setup, ctrl, crc, stuff, nbytes[4:0]}
   localparam int NV = 10;
   localparam logic [8:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 1'b0, 5'd1},
      {1'b0, 1'b0, 1'b0, 1'b0, 5'd4},
      {1'b0, 1'b1, 1'b0, 1'b0, 5'd5},
      {1'b1, 1'b1, 1'b0, 1'b0, 5'd9},
      {1'b1, 1'b0, 1'b0, 1'b0, 5'd9},
      {1'b0, 1'b0, 1'b1, 1'b0, 5'd7},
      {1'b0, 1'b0, 1'b0, 1'b1, 5'd8},
      {1'b0, 1'b0, 1'b0, 1'b0, 5'd16},
      {1'b0, 1'b0, 1'b0, 1'b0, 5'd20},
      {1'b1, 1'b1, 1'b1, 1'b1, 5'd3}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      arm_we = 0; arm_idx = 0; arm_irq = 0; arm_wrap = 0;
      pkt_start = 0; pkt_setup = 0; ep_ctrl = 0; byte_valid = 0; byte_data = 0;
      pkt_end = 0; crc_err = 0; stuff_err = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic arm(input int idx, input bit ie, input bit wr);
      arm_we = 1; arm_idx = 2'(idx); arm_irq = ie; arm_wrap = wr;
      @(negedge clk);
      arm_we = 0; arm_irq = 0; arm_wrap = 0;
   endtask

   task automatic send(input bit setup, input bit ctrl, input int n, input bit ce,
                       input bit se, input logic [7:0] base);
      n_irq = 0; n_ack = 0; n_none = 0;
      pkt_start = 1; pkt_setup = setup; ep_ctrl = ctrl;
      @(negedge clk);
      pkt_start = 0;
      for (int i = 0; i < n; i++) begin
         byte_valid = 1; byte_data = base + 8'(i);
         @(negedge clk);
      end
      byte_valid = 0;
      pkt_end = 1; crc_err = ce; stuff_err = se;
      @(negedge clk);
      pkt_end = 0; crc_err = 0; stuff_err = 0; pkt_setup = 0; ep_ctrl = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input int idx, input int pos);
      rd_idx = 2'(idx); rd_pos = 2'(pos);
      #0.5;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      rst_n = 0;
      rd_idx = 0; rd_pos = 0;
      idle_inputs();
      do_reset();

      // R9 reset state
      chk("R9", "hs_ack", int'(hs_ack), 0);
      chk("R9", "hs_none", int'(hs_none), 0);
      chk("R9", "irq", int'(irq), 0);
      for (int d = 0; d < 4; d++) begin
         rd(d, 0);
         chk("R9", "empty", int'(rd_empty), 0);
         chk("R9", "len", int'(rd_len), 0);
      end

      // table walk: R1 R3 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         int  n, exp_irq, exp_ack, exp_none;
         bit  setup, ctrl, ce, se, acc;
         {setup, ctrl, ce, se} = VEC[v][8:5];
         n = int'(VEC[v][4:0]);
         for (int d = 0; d < 4; d++) arm(d, 1'b1, d == 3);
         send(setup, ctrl, n, ce, se, 8'(16 * v));
         acc = !setup || ctrl;
         if (!acc) begin
            exp_irq = 0; exp_ack = 0; exp_none = 0;
         end else if (n > 16) begin
            exp_irq = 4; exp_ack = 0; exp_none = 1;
         end else begin
            exp_irq  = (n + 3) / 4;
            exp_ack  = (ce || se) ? 0 : 1;
            exp_none = 1 - exp_ack;
         end
         chk(acc ? ((n > 16) ? "R8" : "R6") : "R1", "ack pulses", n_ack, exp_ack);
         chk((ce || se) ? "R7" : "R6", "none pulses", n_none, exp_none);
         chk("R3", "irq pulses", n_irq, exp_irq);
      end

      // R2 R3 R5 R6: spill over two buffers, irq only where enabled
      do_reset();
      arm(0, 1, 0); arm(1, 0, 0); arm(2, 1, 0); arm(3, 0, 1);
      send(0, 0, 6, 0, 0, 8'hA0);
      chk("R6", "ack", n_ack, 1);
      chk("R3", "irq count", n_irq, 1);
      rd(0, 0); chk("R5", "pid byte", int'(rd_data), 'hA0);
      chk("R3", "bd0 empty", int'(rd_empty), 0);
      chk("R3", "bd0 len", int'(rd_len), 4);
      rd(0, 3); chk("R5", "bd0 byte3", int'(rd_data), 'hA3);
      rd(1, 1); chk("R4", "bd1 byte1", int'(rd_data), 'hA5);
      chk("R6", "bd1 len", int'(rd_len), 2);
      chk("R6", "bd1 stat", int'(rd_stat), 0);
      rd(2, 0); chk("R2", "bd2 untouched", int'(rd_empty), 1);

      // R4 wrap on ring-end flag
      do_reset();
      arm(0, 0, 0); arm(1, 0, 1); arm(2, 0, 0);
      send(0, 0, 3, 0, 0, 8'h10);
      send(0, 0, 3, 0, 0, 8'h20);
      rd(1, 0); chk("R4", "bd1 byte0", int'(rd_data), 'h20);
      arm(0, 0, 0);
      send(0, 0, 2, 1, 0, 8'h30);
      chk("R7", "none on crc", n_none, 1);
      chk("R7", "no ack on crc", n_ack, 0);
      rd(0, 0); chk("R4", "wrapped to bd0", int'(rd_data), 'h30);
      chk("R7", "bd0 crc stat", int'(rd_stat), 1);
      chk("R6", "bd0 len", int'(rd_len), 2);
      rd(2, 0); chk("R4", "bd2 skipped", int'(rd_empty), 1);

      // R7 error at exact buffer boundary
      do_reset();
      arm(0, 0, 0); arm(1, 0, 0);
      send(0, 0, 4, 0, 1, 8'h40);
      chk("R7", "none on stuff", n_none, 1);
      rd(0, 0); chk("R7", "bd0 stuff stat", int'(rd_stat), 2);
      chk("R3", "bd0 len full", int'(rd_len), 4);
      rd(1, 0); chk("R7", "bd1 still empty", int'(rd_empty), 1);

      // R10 re-arm clears
      arm(0, 0, 0);
      rd(0, 0);
      chk("R10", "rearm empty", int'(rd_empty), 1);
      chk("R10", "rearm len", int'(rd_len), 0);
      chk("R10", "rearm stat", int'(rd_stat), 0);

      // R8 overrun
      do_reset();
      arm(0, 0, 0);
      send(0, 0, 6, 0, 0, 8'h60);
      chk("R8", "none on overrun", n_none, 1);
      chk("R8", "no ack on overrun", n_ack, 0);
      rd(0, 0); chk("R8", "bd0 busy stat", int'(rd_stat), 4);
      chk("R8", "bd0 len", int'(rd_len), 4);
      rd(0, 3); chk("R8", "bd0 byte3", int'(rd_data), 'h63);
      rd(1, 0); chk("R8", "bd1 not written", int'(rd_empty), 0);
      chk("R8", "bd1 len", int'(rd_len), 0);
      arm(1, 0, 0);
      send(0, 0, 1, 0, 0, 8'h55);
      rd(1, 0); chk("R8", "index held on bd1", int'(rd_data), 'h55);
      chk("R6", "bd1 len 1", int'(rd_len), 1);
      chk("R6", "ack after recovery", n_ack, 1);

      // R1 SETUP on non-control endpoint
      do_reset();
      arm(0, 1, 0);
      send(1, 0, 3, 0, 0, 8'h2A);
      rd(0, 0); chk("R1", "ignored setup empty", int'(rd_empty), 1);
      chk("R1", "ignored setup ack", n_ack, 0);
      chk("R1", "ignored setup none", n_none, 0);
      chk("R1", "ignored setup irq", n_irq, 0);
      send(1, 1, 3, 0, 0, 8'h2D);
      rd(0, 0); chk("R1", "control setup byte0", int'(rd_data), 'h2D);
      chk("R1", "control setup len", int'(rd_len), 3);
      chk("R1", "control setup ack", n_ack, 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule